// File: doc/BRIEF.md
# Banked RAM Expansion Mapper

This block sits beside the CPU of an 8-bit home computer and turns a 16-bit CPU memory address into a 22-bit physical RAM address. It watches I/O write cycles. When a write carries the RAM-select pattern, it captures a 64K bank number and a 3-bit configuration code. For every following memory access it decides, per 16K quarter of the CPU space, whether the access goes to base RAM or to a page of the selected expansion bank. It then drives the resulting physical address together with an expansion-select flag.

The bank number is assembled from two sources:
- The three low bits come from the data bus.
- The upper bits come from inverted I/O address bits 10..8.

Port 7Fxxh therefore reaches the first 512K, and 7Exxh, 7Dxxh and 7Cxxh reach the next three 512K windows. A unit that only fits a slice of the bank space is described by the `BANK_LO`/`BANK_HI` parameters. Banks outside that slice never select expansion RAM.

Top module: `ram_bank_mapper`

## Requirements
- R1: While `rst` is high, and on the first output cycle after it, the stored bank and configuration are 0. `phys_addr` and `exp_sel` read 0 while `rst` is high.
- R2: A write is accepted only when all of these hold in one rising clock edge: `io_req`=1, `wr_req`=1, `cpu_addr[15]`=0 and `cpu_data[7:6]`=2'b11.
- R3: A write with `cpu_data[7:6]` other than 2'b11 leaves bank and configuration unchanged.
- R4: A write with `cpu_addr[15]`=1, or with either of `io_req`/`wr_req` low, leaves bank and configuration unchanged.
- R5: Bank bits [2:0] are taken from `cpu_data[5:3]`.
- R6: Bank bits [5:3] are taken from the inverse of `cpu_addr[10:8]`, so port 7Fxxh gives 0, 7Exxh gives 1, 7Dxxh gives 2 and 7Cxxh gives 3. The configuration code is `cpu_data[2:0]`.
- R7: Configurations 0..3 map the quarters (CPU address bits 15:14 = 0,1,2,3) as follows:
  - 0: base 0,1,2,3.
  - 1: base 0,1,2 and expansion 3.
  - 2: expansion 0,1,2,3.
  - 3: base 0, base 3, base 2 and expansion 3.
- R8: Configurations 4..7 map quarter 1 to expansion page (code-4). Quarters 0, 2 and 3 go to base pages 0, 2 and 3.
- R9: An expansion access yields `phys_addr` = {bank[5:0], page[1:0], cpu_addr[13:0]} with `exp_sel`=1. A base access yields {6'b0, page[1:0], cpu_addr[13:0]} with `exp_sel`=0.
- R10: When the stored bank lies outside [`BANK_LO`,`BANK_HI`], `exp_sel` stays 0 and every quarter maps to its own base page.
- R11: Outputs are registered. The address presented before edge k appears after edge k, and is mapped with the state held before edge k, so a new selection affects accesses from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_data | input | 8 | CPU data bus (write data) |
| io_req | input | 1 | I/O request strobe, active high |
| wr_req | input | 1 | Write strobe, active high |
| phys_addr | output | 22 | Registered physical RAM address |
| exp_sel | output | 1 | Registered: access targets expansion RAM |

## Verification
The hardest situation to reach is a bank that is valid by encoding but lies outside the unit's configured slice. It must fall back to identity base mapping even under configuration 2.

The bench instantiates the block with a raised lower bound of 4. It then writes through port 7Fxxh with low data bank bits below 4, and through port 7Bxxh, whose bank lies above 31. Every configuration is walked over all four quarters for each of these banks.

A second hard case is a write issued in the same cycle as a memory lookup. The reference model checks that such a lookup still uses the old mapping.

// File: rtl/rbm_pkg.sv
package rbm_pkg;
  typedef struct packed {
    logic       is_exp;
    logic [1:0] page;
  } qmap_t;

  function automatic qmap_t map_quarter(input logic [2:0] cfg, input logic [1:0] q);
    qmap_t m;
    m.is_exp = 1'b0;
    m.page   = q;
    case (cfg)
      3'd0: ;
      3'd1: if (q == 2'd3) m.is_exp = 1'b1;
      3'd2: m.is_exp = 1'b1;
      3'd3: begin
        if (q == 2'd1) m.page = 2'd3;
        if (q == 2'd3) m.is_exp = 1'b1;
      end
      default: if (q == 2'd1) begin
        m.is_exp = 1'b1;
        m.page   = cfg[1:0];
      end
    endcase
    return m;
  endfunction
endpackage

// File: rtl/rbm_select_reg.sv
module rbm_select_reg #(
  parameter int AW     = 16,
  parameter int DW     = 8,
  parameter int BANK_W = 6,
  parameter int CFG_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     data,
  input  logic              io_req,
  input  logic              wr_req,
  output logic [BANK_W-1:0] bank_q,
  output logic [CFG_W-1:0]  cfg_q
);
  localparam int LO_W = 3;
  localparam int HI_W = BANK_W - LO_W;

  logic hit;
  logic [BANK_W-1:0] bank_d;

  assign hit    = io_req && wr_req && !addr[AW-1] && (data[DW-1 -: 2] == 2'b11);
  assign bank_d = {~addr[8 +: HI_W], data[CFG_W +: LO_W]};

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_q <= '0;
      cfg_q  <= '0;
    end else if (hit) begin
      bank_q <= bank_d;
      cfg_q  <= data[CFG_W-1:0];
    end
  end

  assert_load_R2: assert property (@(posedge clk) disable iff (rst)
    (io_req && wr_req && !addr[AW-1] && data[DW-1 -: 2] == 2'b11)
    |=> (cfg_q == $past(data[CFG_W-1:0]) && bank_q[LO_W-1:0] == $past(data[CFG_W +: LO_W])));
  assert_qual_ignored_R3: assert property (@(posedge clk) disable iff (rst)
    (data[DW-1 -: 2] != 2'b11) |=> ($stable(bank_q) && $stable(cfg_q)));
  assert_hi_addr_ignored_R4: assert property (@(posedge clk) disable iff (rst)
    (addr[AW-1] || !io_req || !wr_req) |=> ($stable(bank_q) && $stable(cfg_q)));
  assert_upper_inv_R6: assert property (@(posedge clk) disable iff (rst)
    (io_req && wr_req && !addr[AW-1] && data[DW-1 -: 2] == 2'b11)
    |=> (bank_q[BANK_W-1:LO_W] == ~$past(addr[8 +: HI_W])));
endmodule

// File: rtl/rbm_page_map.sv
module rbm_page_map #(
  parameter int CFG_W = 3
) (
  input  logic [CFG_W-1:0] cfg,
  input  logic             bank_ok,
  input  logic [1:0]       quarter,
  output rbm_pkg::qmap_t   qmap
);
  import rbm_pkg::*;
  localparam int NQ = 4;

  qmap_t tbl [NQ];

  for (genvar g = 0; g < NQ; g++) begin : g_quarter
    always_comb begin
      if (bank_ok) tbl[g] = map_quarter(cfg, 2'(g));
      else begin
        tbl[g].is_exp = 1'b0;
        tbl[g].page   = 2'(g);
      end
    end
  end

  assign qmap = tbl[quarter];
endmodule

// File: rtl/rbm_addr_out.sv
module rbm_addr_out #(
  parameter int BANK_W = 6,
  parameter int OFS_W  = 14,
  parameter int PA_W   = BANK_W + 2 + OFS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OFS_W-1:0]  offset,
  input  logic [BANK_W-1:0] bank,
  input  rbm_pkg::qmap_t    qmap,
  output logic [PA_W-1:0]   phys_addr,
  output logic              exp_sel
);
  logic [BANK_W-1:0] hi;
  assign hi = qmap.is_exp ? bank : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      phys_addr <= '0;
      exp_sel   <= 1'b0;
    end else begin
      phys_addr <= {hi, qmap.page, offset};
      exp_sel   <= qmap.is_exp;
    end
  end

  assert_offset_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (phys_addr[OFS_W-1:0] == $past(offset)));
  assert_base_upper_R9: assert property (@(posedge clk) disable iff (rst)
    !exp_sel |-> (phys_addr[PA_W-1 -: BANK_W] == '0));
endmodule

// File: rtl/ram_bank_mapper.sv
module ram_bank_mapper #(
  parameter int AW      = 16,
  parameter int DW      = 8,
  parameter int BANK_W  = 6,
  parameter int CFG_W   = 3,
  parameter int BANK_LO = 0,
  parameter int BANK_HI = 31,
  parameter int OFS_W   = AW - 2,
  parameter int PA_W    = BANK_W + 2 + OFS_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AW-1:0]   cpu_addr,
  input  logic [DW-1:0]   cpu_data,
  input  logic            io_req,
  input  logic            wr_req,
  output logic [PA_W-1:0] phys_addr,
  output logic            exp_sel
);
  import rbm_pkg::*;

  logic [BANK_W-1:0] bank_q;
  logic [CFG_W-1:0]  cfg_q;
  logic              bank_ok;
  qmap_t             qmap;

  rbm_select_reg #(.AW(AW), .DW(DW), .BANK_W(BANK_W), .CFG_W(CFG_W)) u_reg (
    .clk(clk), .rst(rst), .addr(cpu_addr), .data(cpu_data),
    .io_req(io_req), .wr_req(wr_req), .bank_q(bank_q), .cfg_q(cfg_q)
  );

  assign bank_ok = (int'(bank_q) >= BANK_LO) && (int'(bank_q) <= BANK_HI);

  rbm_page_map #(.CFG_W(CFG_W)) u_map (
    .cfg(cfg_q), .bank_ok(bank_ok), .quarter(cpu_addr[AW-1 -: 2]), .qmap(qmap)
  );

  rbm_addr_out #(.BANK_W(BANK_W), .OFS_W(OFS_W), .PA_W(PA_W)) u_out (
    .clk(clk), .rst(rst), .offset(cpu_addr[OFS_W-1:0]), .bank(bank_q),
    .qmap(qmap), .phys_addr(phys_addr), .exp_sel(exp_sel)
  );

  assert_range_R10: assert property (@(posedge clk) disable iff (rst)
    exp_sel |-> (int'($past(bank_q)) >= BANK_LO && int'($past(bank_q)) <= BANK_HI));
  assert_exp_bank_R9: assert property (@(posedge clk) disable iff (rst)
    exp_sel |-> (phys_addr[PA_W-1 -: BANK_W] == $past(bank_q)));
  assert_cfg0_base_R7: assert property (@(posedge clk) disable iff (rst)
    (cfg_q == '0) |=> !exp_sel);
endmodule

// File: tb/sim_ram_bank_mapper.sv
module sim_ram_bank_mapper;
  localparam int LO = 4;
  localparam int HI = 31;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_data = '0;
  logic        io_req = 1'b0;
  logic        wr_req = 1'b0;
  logic [21:0] phys_addr;
  logic        exp_sel;

  int n_cmp = 0;
  int n_bad = 0;
  int m_bank = 0;
  int m_cfg = 0;

  always #5 clk = ~clk;

  ram_bank_mapper #(.BANK_LO(LO), .BANK_HI(HI)) u0 (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .io_req(io_req), .wr_req(wr_req), .phys_addr(phys_addr), .exp_sel(exp_sel)
  );

  task automatic check(input string tag, input logic [21:0] ea, input logic es);
    n_cmp++;
    if (phys_addr !== ea || exp_sel !== es) begin
      n_bad++;
      $display("FAIL %s: got addr=%h sel=%b expected addr=%h sel=%b",
               tag, phys_addr, exp_sel, ea, es);
    end
  endtask

  function automatic void model_map(input logic [15:0] a, output logic [21:0] ea, output logic es);
    int q, pg;
    bit ex;
    q = a[15:14]; pg = q; ex = 0;
    if (m_bank >= LO && m_bank <= HI) begin
      if (m_cfg == 1 && q == 3) ex = 1;
      else if (m_cfg == 2) ex = 1;
      else if (m_cfg == 3) begin
        if (q == 1) pg = 3;
        if (q == 3) ex = 1;
      end else if (m_cfg >= 4 && q == 1) begin
        ex = 1; pg = m_cfg - 4;
      end
    end
    es = ex;
    ea = {(ex ? 6'(m_bank) : 6'd0), 2'(pg), a[13:0]};
  endfunction

  // Called at a negedge: drive, predict with pre-edge state, advance model, compare at next negedge.
  task automatic step(input logic [15:0] a, input logic [7:0] d, input logic io, input logic w,
                      input string tag);
    logic [21:0] ea;
    logic es;
    cpu_addr = a; cpu_data = d; io_req = io; wr_req = w;
    model_map(a, ea, es);
    if (io && w && !a[15] && d[7:6] == 2'b11) begin
      m_bank = int'((~a[10:8]) & 3'h7) * 8 + int'(d[5:3]);
      m_cfg  = int'(d[2:0]);
    end
    @(negedge clk);
    check(tag, ea, es);
  endtask

  task automatic sel(input logic [7:0] port, input int lo3, input int cfg, input string tag);
    step({port, 8'h80}, {2'b11, 3'(lo3), 3'(cfg)}, 1'b1, 1'b1, tag);
  endtask

  task automatic sweep(input string tag);
    for (int q = 0; q < 4; q++) step({2'(q), 14'h1A5 + 14'(q * 77)}, 8'h00, 1'b0, 1'b0, tag);
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R1: reset state
    cpu_addr = 16'hC123;
    repeat (3) @(negedge clk);
    check("R1 reset outputs", 22'h0, 1'b0);
    rst = 1'b0;
    sweep("R1 post-reset bank 0 out of range -> base");

    // R5/R6/R7: ports and low bits, configs 0..3
    sel(8'h7F, 5, 2, "R5 write port 7F");
    sweep("R7 cfg2 bank5");
    sel(8'h7E, 3, 1, "R6 write port 7E");
    sweep("R7 cfg1 bank11");
    sel(8'h7D, 0, 3, "R6 write port 7D");
    sweep("R7 cfg3 bank16");
    sel(8'h7C, 7, 0, "R6 write port 7C");
    sweep("R7 cfg0 bank31");

    // R8: configs 4..7
    for (int c = 4; c < 8; c++) begin
      sel(8'h7E, c - 2, c, "R8 write");
      sweep("R8 cfg4-7");
    end

    // R3: qualifier other than 11
    sel(8'h7F, 6, 2, "R2 write");
    step(16'h7F80, 8'h5F, 1'b1, 1'b1, "R3 data 01 ignored");
    step(16'h7F80, 8'h87, 1'b1, 1'b1, "R3 data 10 ignored");
    step(16'h7F80, 8'h3D, 1'b1, 1'b1, "R3 data 00 ignored");
    sweep("R3 mapping unchanged");

    // R4: A15 set, strobes missing
    step(16'hFE80, 8'hC1, 1'b1, 1'b1, "R4 A15 ignored");
    step(16'h7D80, 8'hC1, 1'b0, 1'b1, "R4 no io_req ignored");
    step(16'h7D80, 8'hC1, 1'b1, 1'b0, "R4 no wr_req ignored");
    sweep("R4 mapping unchanged");

    // R10: out-of-range banks (below LO via 7F, above HI via 7B)
    for (int c = 0; c < 8; c++) begin
      sel(8'h7F, c & 3, c, "R10 low bank write");
      sweep("R10 below range base");
      sel(8'h7B, c, c, "R10 high bank write");
      sweep("R10 above range base");
    end

    // R11: write and lookup in the same cycle use old mapping; new from next cycle
    sel(8'h7F, 5, 0, "R11 setup");
    step(16'h7C80, 8'hFA, 1'b1, 1'b1, "R11 same-cycle old mapping");
    step(16'hC010, 8'h00, 1'b0, 1'b0, "R11 next-cycle new mapping");
    step(16'h4010, 8'h00, 1'b0, 1'b0, "R9 expansion address form");

    // R9/R2: exhaustive ports x cfg at quarter 3
    for (int p = 0; p < 8; p++)
      for (int c = 0; c < 8; c++) begin
        sel(8'h78 + 8'(p), (p + c) & 7, c, "R2 sweep write");
        step(16'hFFFF, 8'h00, 1'b0, 1'b0, "R9 sweep q3");
        step(16'h4000, 8'h00, 1'b0, 1'b0, "R9 sweep q1");
      end

    // R1 again: reset mid-run clears state
    sel(8'h7E, 2, 2, "R1 pre-reset write");
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R1 reset outputs again", 22'h0, 1'b0);
    m_bank = 0; m_cfg = 0;
    rst = 1'b0;
    sweep("R1 cleared after reset");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule